// File: doc/BRIEF.md
# Serialized Interrupt Bus Host

This block is the host end of a single-wire serialized interrupt bus that runs on the bus clock. Each bus cycle opens with a Start Frame, either on the host's own initiative or in answer to an agent that pulled the idle line low. A run of three-clock data periods follows. The host samples the shared line once in each period, rebuilds a sixteen-entry interrupt level vector and a system-management bit from those samples, and then closes the cycle with a Stop Frame. The width of the Stop Frame tells every agent which start mode applies to the next cycle.

In Continuous mode the host opens every cycle on its own. In Quiet mode it leaves the line alone until an agent starts a cycle, and then drives the rest of the Start Frame. The line is modelled as a pulled-up open bus. The host drives it through an output enable and a drive value, and the surrounding logic feeds the resolved line level back on `sirq_in`. Every output is a plain level or strobe, so the block has no stream handshake and applies no back-pressure.

Clock numbering used below: clock S is the clock in which the host drives the line high at the end of the Start Frame, and S+j is the j-th clock after it. N is the effective frame count.

Top module: `sirq_host`

## Requirements
- R1: While `rst_n` is low, `sirq_oe` is 0, `irq_vec` is all ones, `smi_n` is 1 and `cycle_done` is 0. The block leaves reset in Continuous mode.
- R2: In Continuous mode, in the clock after the host is found idle, it starts driving a Start Frame: `sirq_oe`=1 with `sirq_out`=0 for 4 clocks, then `sirq_out`=1 for one clock (clock S).
- R3: In Quiet mode the host drives nothing while idle. When it samples `sirq_in` low in an idle clock, it drives the line low for the next 3 clocks and then high for one clock (clock S).
- R4: Period k (k ≥ 1) is sampled from `sirq_in` in clock S+3k−1. For k = 1, 2 and 4 to 16, a low sample gives 0 and a high sample gives 1 in `irq_vec[k-1]`.
- R5: When `p3_to_smi`=1 in the period-3 sample clock, that sample goes to `smi_n` and `irq_vec[2]` becomes 1. When it is 0, the sample goes to `irq_vec[2]` and `smi_n` becomes 1.
- R6: `frame_cnt` is read in clock S and clamped to the range 17 to 32, giving N. The host releases the line from S+1 through S+3N, and the Stop Frame begins in clock S+3N+1.
- R7: `cont_req` is read in clock S+3N. The Stop Frame then drives the line low for 3 clocks if it was 1, or for 2 clocks if it was 0. The host then drives the line high for one clock and releases it. That value sets the mode of the following cycle.
- R8: In Continuous mode, exactly one released clock separates the Stop Frame's high clock from the first low clock of the next Start Frame.
- R9: `irq_vec` and `smi_n` change only in the clock in which `cycle_done` is 1. `cycle_done` is a one-clock pulse in clock S+3N+1, the first Stop Frame clock.
- R10: After a Stop Frame that selects Quiet mode, the host never drives the line until an agent starts a cycle. A change of `cont_req` at any clock other than S+3N does not alter the current cycle.
- R11: Samples taken in periods 17 to N have no effect on `irq_vec` or `smi_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sirq_in | input | 1 | Resolved level of the shared interrupt line |
| cont_req | input | 1 | Mode request for the next cycle: 1 Continuous, 0 Quiet |
| p3_to_smi | input | 1 | Routes the period-3 sample to `smi_n` when 1, to `irq_vec[2]` when 0 |
| frame_cnt | input | 6 | Requested number of data periods per cycle (clamped to 17..32) |
| sirq_oe | output | 1 | Host drives the line when 1 |
| sirq_out | output | 1 | Value driven while `sirq_oe` is 1 |
| irq_vec | output | 16 | Interrupt levels from the last completed cycle, bit i = IRQi |
| smi_n | output | 1 | System-management level from period 3, active low |
| cycle_done | output | 1 | One-clock pulse when new levels are presented |

## Verification
The line drive results are due in the same clock as their position in the frame: the four or three low start clocks, clock S, the released data clocks, and the stop clocks that follow S+3N. A sample taken in S+3k−1 reaches the outputs only in S+3N+1, together with `cycle_done`. A mode request read in S+3N shows up in the length of the stop pulse that begins in the next clock. The bench model places every expectation by its position counted from the start of the current frame. It compares all outputs at the falling edge of each clock, so each result is checked in exactly the clock in which it is due.

// File: rtl/sirq_host_pkg.sv
`timescale 1ns/1ps
package sirq_host_pkg;

  // Bus-cycle phases of the host sequencer
  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_START_LO = 3'd1,
    SQ_START_HI = 3'd2,
    SQ_DATA     = 3'd3,
    SQ_STOP_LO  = 3'd4,
    SQ_STOP_HI  = 3'd5
  } sq_state_e;

  // Clock slots inside one three-clock data period
  localparam logic [1:0] SLOT_LEAD   = 2'd0;
  localparam logic [1:0] SLOT_SAMPLE = 2'd1;
  localparam logic [1:0] SLOT_TAIL   = 2'd2;

endpackage

// File: rtl/sirq_frame_limit.sv
`timescale 1ns/1ps
module sirq_frame_limit #(
  parameter int FCW        = 6,
  parameter int PW         = 6,
  parameter int MIN_FRAMES = 17,
  parameter int MAX_FRAMES = 32
) (
  input  logic [FCW-1:0] req_frames,
  output logic [PW-1:0]  eff_frames
);

  // Clamp the requested period count into the supported range
  always_comb begin
    if (int'(req_frames) < MIN_FRAMES)
      eff_frames = PW'(MIN_FRAMES);
    else if (int'(req_frames) > MAX_FRAMES)
      eff_frames = PW'(MAX_FRAMES);
    else
      eff_frames = PW'(req_frames);
  end

endmodule

// File: rtl/sirq_sequencer.sv
`timescale 1ns/1ps
module sirq_sequencer
  import sirq_host_pkg::*;
#(
  parameter int START_LEN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int PW         = 6,
  parameter int MIN_FRAMES = 17,
  parameter int MAX_FRAMES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sirq_in,
  input  logic          cont_req,
  input  logic [PW-1:0] n_frames,
  output logic          drive_en,
  output logic          drive_val,
  output logic          sample_en,
  output logic [PW-1:0] period,
  output logic          cycle_end
);

  localparam int LCW = $clog2(START_LEN + 1);

  sq_state_e      state;
  logic [LCW-1:0] lo_cnt;
  logic [1:0]     slot;
  logic [PW-1:0]  per;
  logic [PW-1:0]  n_lat;
  logic           mode_cont;
  logic           last_clk;

  assign last_clk = (state == SQ_DATA) && (slot == SLOT_TAIL) && (per == n_lat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      lo_cnt    <= '0;
      slot      <= SLOT_LEAD;
      per       <= '0;
      n_lat     <= '0;
      mode_cont <= 1'b1;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (mode_cont) begin
            state  <= SQ_START_LO;
            lo_cnt <= LCW'(START_LEN - 1);
          end else if (!sirq_in) begin
            // agent already held the line for one clock
            state  <= SQ_START_LO;
            lo_cnt <= LCW'(START_LEN - 2);
          end
        end
        SQ_START_LO: begin
          if (lo_cnt == '0) state <= SQ_START_HI;
          else              lo_cnt <= lo_cnt - 1'b1;
        end
        SQ_START_HI: begin
          state <= SQ_DATA;
          slot  <= SLOT_LEAD;
          per   <= PW'(1);
          n_lat <= n_frames;
        end
        SQ_DATA: begin
          if (slot == SLOT_TAIL) begin
            slot <= SLOT_LEAD;
            if (per == n_lat) begin
              state     <= SQ_STOP_LO;
              mode_cont <= cont_req;
              lo_cnt    <= cont_req ? LCW'(STOP_CONT - 1) : LCW'(STOP_QUIET - 1);
            end else begin
              per <= per + PW'(1);
            end
          end else begin
            slot <= slot + 2'd1;
          end
        end
        SQ_STOP_LO: begin
          if (lo_cnt == '0) state <= SQ_STOP_HI;
          else              lo_cnt <= lo_cnt - 1'b1;
        end
        SQ_STOP_HI: state <= SQ_IDLE;
        default:    state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    drive_en  = (state == SQ_START_LO) || (state == SQ_START_HI) ||
                (state == SQ_STOP_LO)  || (state == SQ_STOP_HI);
    drive_val = (state == SQ_START_HI) || (state == SQ_STOP_HI);
    sample_en = (state == SQ_DATA) && (slot == SLOT_SAMPLE);
    period    = per;
    cycle_end = last_clk;
  end

  // Run-length trackers for the frame-width checks
  logic [LCW:0] start_run;
  logic [LCW:0] stop_run;
  logic         agent_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_run   <= '0;
      stop_run    <= '0;
      agent_start <= 1'b0;
    end else begin
      start_run <= (state == SQ_START_LO) ? start_run + 1'b1 : '0;
      stop_run  <= (state == SQ_STOP_LO)  ? stop_run + 1'b1  : '0;
      if (state == SQ_IDLE) agent_start <= !mode_cont;
    end
  end

  AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_START_HI) |->
      (start_run == (agent_start ? (LCW+1)'(START_LEN - 1) : (LCW+1)'(START_LEN)))); // R2

  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_START_LO && $past(state) == SQ_IDLE && !mode_cont) |-> !$past(sirq_in)); // R3

  AST_STOP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_STOP_HI) |->
      (stop_run == (mode_cont ? (LCW+1)'(STOP_CONT) : (LCW+1)'(STOP_QUIET)))); // R7

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_DATA) |-> (n_lat >= PW'(MIN_FRAMES) && n_lat <= PW'(MAX_FRAMES))); // R6

endmodule

// File: rtl/sirq_capture.sv
`timescale 1ns/1ps
module sirq_capture #(
  parameter int NUM_IRQ    = 16,
  parameter int PW         = 6,
  parameter int SMI_PERIOD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sirq_in,
  input  logic               p3_to_smi,
  input  logic               sample_en,
  input  logic [PW-1:0]      period,
  input  logic               cycle_end,
  output logic [NUM_IRQ-1:0] irq_vec,
  output logic               smi_n,
  output logic               cycle_done
);

  logic [NUM_IRQ-1:0] shadow;
  logic               shadow_smi;
  logic [NUM_IRQ-1:0] wr_hit;
  logic [NUM_IRQ-1:0] wr_val;
  logic               smi_hit;

  // One write lane per interrupt; the shared period picks its routing
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_lane
    localparam int PER = gi + 1;
    assign wr_hit[gi] = sample_en && (period == PW'(PER));
    if (PER == SMI_PERIOD) begin : g_shared
      assign wr_val[gi] = p3_to_smi ? 1'b1 : sirq_in;
    end else begin : g_plain
      assign wr_val[gi] = sirq_in;
    end
  end

  assign smi_hit = sample_en && (period == PW'(SMI_PERIOD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow     <= '1;
      shadow_smi <= 1'b1;
    end else begin
      shadow <= (shadow & ~wr_hit) | (wr_val & wr_hit);
      if (smi_hit) shadow_smi <= p3_to_smi ? sirq_in : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_vec    <= '1;
      smi_n      <= 1'b1;
      cycle_done <= 1'b0;
    end else begin
      cycle_done <= cycle_end;
      if (cycle_end) begin
        irq_vec <= shadow;
        smi_n   <= shadow_smi;
      end
    end
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cycle_end) |-> ($stable(irq_vec) && $stable(smi_n))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done); // R9

  AST_P3_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_vec[SMI_PERIOD-1] == 1'b0 && smi_n == 1'b0)); // R5

endmodule

// File: rtl/sirq_host.sv
`timescale 1ns/1ps
module sirq_host #(
  parameter int NUM_IRQ    = 16,
  parameter int FCW        = 6,
  parameter int MIN_FRAMES = 17,
  parameter int MAX_FRAMES = 32,
  parameter int START_LEN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int SMI_PERIOD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sirq_in,
  input  logic               cont_req,
  input  logic               p3_to_smi,
  input  logic [FCW-1:0]     frame_cnt,
  output logic               sirq_oe,
  output logic               sirq_out,
  output logic [NUM_IRQ-1:0] irq_vec,
  output logic               smi_n,
  output logic               cycle_done
);

  localparam int PW = $clog2(MAX_FRAMES + 1);

  logic [PW-1:0] eff_frames;
  logic          sample_en;
  logic [PW-1:0] period;
  logic          cycle_end;

  sirq_frame_limit #(
    .FCW(FCW), .PW(PW), .MIN_FRAMES(MIN_FRAMES), .MAX_FRAMES(MAX_FRAMES)
  ) u_limit (
    .req_frames (frame_cnt),
    .eff_frames (eff_frames)
  );

  sirq_sequencer #(
    .START_LEN(START_LEN), .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT),
    .PW(PW), .MIN_FRAMES(MIN_FRAMES), .MAX_FRAMES(MAX_FRAMES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sirq_in   (sirq_in),
    .cont_req  (cont_req),
    .n_frames  (eff_frames),
    .drive_en  (sirq_oe),
    .drive_val (sirq_out),
    .sample_en (sample_en),
    .period    (period),
    .cycle_end (cycle_end)
  );

  sirq_capture #(
    .NUM_IRQ(NUM_IRQ), .PW(PW), .SMI_PERIOD(SMI_PERIOD)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sirq_in    (sirq_in),
    .p3_to_smi  (p3_to_smi),
    .sample_en  (sample_en),
    .period     (period),
    .cycle_end  (cycle_end),
    .irq_vec    (irq_vec),
    .smi_n      (smi_n),
    .cycle_done (cycle_done)
  );

endmodule

// File: tb/sirq_host_test.sv
`timescale 1ns/1ps
module sirq_host_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cont_req = 1'b1;
  logic        p3_smi = 1'b0;
  logic [5:0]  frame_cnt = 6'd17;
  logic        agent_val = 1'b1;
  logic        agent_kick = 1'b0;
  logic        sirq_oe, sirq_out, smi_n, cycle_done;
  logic [15:0] irq_vec;
  wire         line = sirq_oe ? sirq_out : agent_val;

  always #2.5 clk = ~clk;

  sirq_host uut (
    .clk(clk), .rst_n(rst_n), .sirq_in(line), .cont_req(cont_req),
    .p3_to_smi(p3_smi), .frame_cnt(frame_cnt), .sirq_oe(sirq_oe),
    .sirq_out(sirq_out), .irq_vec(irq_vec), .smi_n(smi_n),
    .cycle_done(cycle_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int data_mode = 0;

  // Reference model state: position inside the current frame
  bit          m_active, m_agent, m_cont, m_done;
  int          m_pos, m_n, m_w, de, k;
  logic [15:0] m_vec, m_vec_sh;
  logic        m_smi, m_smi_sh, e_oe, e_val;
  string       e_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (clock %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int clampf(input int v);
    if (v < 17) return 17;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic void expect_line(output logic oe, output logic v, output string tg);
    int d_end;
    oe = 1'b0; v = 1'b0;
    tg = m_cont ? "R8 idle gap" : "R10 quiet idle";
    if (m_active) begin
      d_end = 4 + 3 * m_n;
      if (m_pos <= 3) begin
        oe = !(m_agent && m_pos == 0);
        tg = m_agent ? "R3 agent start" : "R2 host start";
      end else if (m_pos == 4) begin
        oe = 1'b1; v = 1'b1; tg = "R2 start high";
      end else if (m_pos <= d_end) begin
        tg = "R6 data released";
      end else if (m_pos <= d_end + m_w) begin
        oe = 1'b1; tg = "R7 stop low";
      end else begin
        oe = 1'b1; v = 1'b1; tg = "R7 stop high";
      end
    end
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_active = 0; m_agent = 0; m_cont = 1; m_done = 0;
      m_pos = 0; m_n = 17; m_w = 3;
      m_vec = '1; m_vec_sh = '1; m_smi = 1'b1; m_smi_sh = 1'b1;
    end else begin
      expect_line(e_oe, e_val, e_tag);
      chk(e_tag, 32'(sirq_oe), 32'(e_oe));
      if (e_oe) chk(e_tag, 32'(sirq_out), 32'(e_val));
      chk("R4/R11 irq_vec", 32'(irq_vec), 32'(m_vec));
      chk("R5 smi_n", 32'(smi_n), 32'(m_smi));
      chk("R9 cycle_done", 32'(cycle_done), 32'(m_done));
      m_done = 0;
      if (!m_active) begin
        if (m_cont) begin
          m_active = 1; m_pos = 0; m_agent = 0;
        end else if (!line) begin
          m_active = 1; m_pos = 1; m_agent = 1;
        end
      end else begin
        if (m_pos == 4) m_n = clampf(int'(frame_cnt));
        de = 4 + 3 * m_n;
        if (m_pos > 4 && m_pos <= de && ((m_pos - 4) % 3) == 2) begin
          k = (m_pos - 3) / 3;
          if (k == 3) begin
            if (p3_smi) begin m_smi_sh = line; m_vec_sh[2] = 1'b1; end
            else begin m_vec_sh[2] = line; m_smi_sh = 1'b1; end
          end else if (k >= 1 && k <= 16) begin
            m_vec_sh[k-1] = line;
          end
        end
        if (m_pos == de) begin
          m_vec = m_vec_sh; m_smi = m_smi_sh; m_done = 1;
          m_cont = cont_req; m_w = cont_req ? 3 : 2;
        end
        if (m_pos == de + m_w + 1) m_active = 0;
        else m_pos++;
      end
    end
  end

  // Agents: data levels in the data window, optional start pulse when idle
  always @(posedge clk) begin
    #1;
    if (rst_n && !m_active && !m_cont && agent_kick) begin
      agent_val = 1'b0;
      agent_kick = 1'b0;
    end else if (m_active && m_pos >= 5 && m_pos <= 4 + 3 * m_n) begin
      case (data_mode)
        1:       agent_val = 1'b0;
        2:       agent_val = 1'b1;
        3:       agent_val = m_pos[1];
        default: agent_val = 1'($urandom % 2);
      endcase
    end else begin
      agent_val = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d clocks expected completion", cyc);
      finish_run();
    end
  end

  task automatic wait_done(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!cycle_done);
    end
    #1;
  endtask

  task automatic idle_then_kick(input int clocks);
    repeat (clocks) @(negedge clk);
    #1;
    agent_kick = 1'b1;
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk("R1 oe in reset", 32'(sirq_oe), 32'd0);
      chk("R1 irq_vec in reset", 32'(irq_vec), 32'hffff);
      chk("R1 smi_n in reset", 32'(smi_n), 32'd1);
      chk("R1 cycle_done in reset", 32'(cycle_done), 32'd0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    wait_done(3);                                   // R2 R4 R8 random levels
    frame_cnt = 6'd5;  wait_done(2);                // R6 clamp low
    frame_cnt = 6'd25; data_mode = 3; wait_done(2); // R6 R11 in-range count
    frame_cnt = 6'd40; data_mode = 1; wait_done(2); // R6 clamp high, all low
    frame_cnt = 6'd17; data_mode = 2; wait_done(2); // all high
    p3_smi = 1'b1; data_mode = 0; wait_done(3);     // R5 routing to SMI
    data_mode = 1; wait_done(2);

    cont_req = 1'b0; wait_done(1);                  // R7 next stop is quiet
    idle_then_kick(25);                             // R10 no self start
    repeat (30) @(negedge clk);
    #1 cont_req = 1'b1;                             // R10 mid-cycle change
    data_mode = 0; p3_smi = 1'b0;
    wait_done(1);                                   // R7 wide stop
    wait_done(2);                                   // R8 back to continuous

    frame_cnt = 6'd20; cont_req = 1'b0; wait_done(1);
    idle_then_kick(10);                             // R3 agent start
    wait_done(1);
    #1 cont_req = 1'b1;
    idle_then_kick(6);
    wait_done(2);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule